// File: doc/BRIEF.md
# Four-Bit Function-Select ALU

A purely combinational arithmetic logic unit for four-bit operands (width set by a parameter). A four-bit select code together with a mode pin picks one of sixteen bitwise logic functions or one of sixteen arithmetic functions. Several of the arithmetic functions are mixed forms, such as A plus (A AND NOT B). The carry pins are active-low: a carry-in pin of 1 means no carry enters the sum, and a carry-out pin of 0 means a carry leaves it. The operand and result pins are used as raw vectors. The function table applies to their pin values with no further inversion.

Every arithmetic function is built as the sum of two per-bit terms plus the carry. The low two select bits pick the first term: A, A OR B, A OR NOT B, or all ones. The high two select bits pick the second term: zero, A AND NOT B, A AND B, or A. A lookahead network turns the per-bit generate and propagate signals into the carry chain, into group generate and group propagate outputs (both active-low), and into the carry out. In logic mode the carry into every bit is blocked, so each result bit depends only on its own operand bits. An all-ones flag on the result serves as an equality detector when the unit subtracts.

Top module: `quad_alu`

## Requirements
- R1: With logicMode=1, select codes 0 to 15 give, in order: NOT A; NOT A AND NOT B; NOT A AND B; 0; NOT(A AND B); NOT B; A XOR B; A AND NOT B; NOT A OR B; NOT(A XOR B); B; A AND B; all ones; A OR NOT B; A OR B; A.
- R2: With logicMode=0 and carryInN=1, select codes 0 to 15 give, modulo 16, in order: A; A OR B; A OR NOT B; all ones; A+(A AND NOT B); (A OR B)+(A AND NOT B); A-B-1; (A AND NOT B)-1; A+(A AND B); A+B; (A OR NOT B)+(A AND B); (A AND B)-1; A+A; (A OR B)+A; (A OR NOT B)+A; A-1.
- R3: With logicMode=0 and carryInN=0, the result is the R2 value plus one, modulo 16. Select code 9 then gives A+B+1.
- R4: With logicMode=1, carryInN has no effect on the result.
- R5: carryOutN is the inverse of bit 4 of the full sum in every mode. In this sum, "minus 1" is counted as adding 1111, A-B-1 as A plus NOT B, and a plain term as that term plus 0. The sum includes the carry in, which is asserted when carryInN=0.
- R6: Taken in their asserted (low) sense, carry out equals group generate OR (group propagate AND carry in). Group generate is asserted exactly when the R5 sum carries out with no carry in.
- R7: allOnes is 1 exactly when every result bit is 1. With select code 6, logicMode=0 and carryInN=1, this flags A equal to B.
- R8: The result is a constant, independent of A and B, in three cases: logic code 3 gives 0000, logic code 12 gives 1111, and arithmetic code 3 with carryInN=1 gives 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4 | Operand A |
| opB | input | 4 | Operand B |
| funcSel | input | 4 | Function select code |
| logicMode | input | 1 | 1 selects the logic functions, 0 the arithmetic functions |
| carryInN | input | 1 | Carry in, active-low |
| result | output | 4 | Function result |
| carryOutN | output | 1 | Carry out, active-low |
| grpGenN | output | 1 | Group generate, active-low |
| grpPropN | output | 1 | Group propagate, active-low |
| allOnes | output | 1 | High when every result bit is high |

## Verification
There is no register between the pins, so the result, the carry out, the group outputs and the all-ones flag are all due in the same cycle as the inputs that produce them. The bench applies each input set one time unit after a rising edge. It samples every output at the falling edge of that same cycle, once the logic has settled and well away from the next change of the inputs. Every select code is swept over all operand pairs in both modes and with both carry values. Seeded random vectors and directed checks of the constant and equality cases follow.

// File: rtl/quad_alu_pkg.sv
package quad_alu_pkg;
  typedef enum logic [1:0] {X_A = 2'd0, X_AORB = 2'd1, X_AORNB = 2'd2, X_ONES = 2'd3} xsel_e;
  typedef enum logic [1:0] {Y_ZERO = 2'd0, Y_ANDNB = 2'd1, Y_AND = 2'd2, Y_A = 2'd3} ysel_e;

  typedef struct packed {
    xsel_e xSel;
    ysel_e ySel;
    logic  carryBlock;
    logic  carryIn;
  } aluCtrl_t;
endpackage

// File: rtl/quad_alu_control.sv
module quad_alu_control
  import quad_alu_pkg::*;
(
  input  logic [3:0] funcSel,
  input  logic       logicMode,
  input  logic       carryInN,
  output aluCtrl_t   ctrl
);
  always_comb begin
    ctrl.xSel       = xsel_e'(funcSel[1:0]);
    ctrl.ySel       = ysel_e'(funcSel[3:2]);
    ctrl.carryBlock = logicMode;
    ctrl.carryIn    = ~carryInN;
  end
endmodule

// File: rtl/quad_alu_datapath.sv
module quad_alu_datapath
  import quad_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             grpGen,
  output logic             grpProp
);
  localparam int LAST = WIDTH - 1;

  logic [LAST:0] xTerm, yTerm, gen, prop, halfSum, carryVec;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign xTerm[i] = (ctrl.xSel == X_A)    ? opA[i] :
                      (ctrl.xSel == X_AORB) ? (opA[i] | opB[i]) :
                      (ctrl.xSel == X_AORNB) ? (opA[i] | ~opB[i]) : 1'b1;
    assign yTerm[i] = (ctrl.ySel == Y_ZERO)  ? 1'b0 :
                      (ctrl.ySel == Y_ANDNB) ? (opA[i] & ~opB[i]) :
                      (ctrl.ySel == Y_AND)   ? (opA[i] & opB[i]) : opA[i];
    assign gen[i]     = xTerm[i] & yTerm[i];
    assign prop[i]    = xTerm[i] | yTerm[i];
    assign halfSum[i] = prop[i] & ~gen[i];
    // blocking the carry forces every sum bit to the inverted half sum
    assign result[i]  = halfSum[i] ^ (ctrl.carryBlock | carryVec[i]);
  end

  always_comb begin
    logic c, gAcc, pAcc;
    c    = ctrl.carryIn;
    gAcc = 1'b0;
    pAcc = 1'b1;
    for (int i = 0; i < WIDTH; i++) begin
      carryVec[i] = c;
      c    = gen[i] | (prop[i] & c);
      gAcc = gen[i] | (prop[i] & gAcc);
      pAcc = pAcc & prop[i];
    end
    carryOut = c;
    grpGen   = gAcc;
    grpProp  = pAcc;
  end
endmodule

// File: rtl/quad_alu.sv
module quad_alu
  import quad_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       funcSel,
  input  logic             logicMode,
  input  logic             carryInN,
  output logic [WIDTH-1:0] result,
  output logic             carryOutN,
  output logic             grpGenN,
  output logic             grpPropN,
  output logic             allOnes
);
  aluCtrl_t ctrl;
  logic carryOut, grpGen, grpProp;

  quad_alu_control u_ctrl (
    .funcSel(funcSel), .logicMode(logicMode), .carryInN(carryInN), .ctrl(ctrl)
  );

  quad_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA(opA), .opB(opB), .ctrl(ctrl), .result(result),
    .carryOut(carryOut), .grpGen(grpGen), .grpProp(grpProp)
  );

  assign carryOutN = ~carryOut;
  assign grpGenN   = ~grpGen;
  assign grpPropN  = ~grpProp;
  assign allOnes   = &result;
endmodule

// File: rtl/quad_alu_checker.sv
module quad_alu_checker #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       funcSel,
  input logic             logicMode,
  input logic             carryInN,
  input logic [WIDTH-1:0] result,
  input logic             carryOutN,
  input logic             grpGenN,
  input logic             grpPropN,
  input logic             allOnes
);
  logic [WIDTH:0] addSum;
  assign addSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, ~carryInN};

  always_comb begin
    assert_eq_flag_R7: assert (allOnes == (result == {WIDTH{1'b1}}))
      else $error("allOnes disagrees with result");
    assert_lookahead_R6: assert ((~carryOutN) == ((~grpGenN) | ((~grpPropN) & ~carryInN)))
      else $error("carry out disagrees with group terms");
    if (!logicMode && funcSel == 4'd9)
      assert_add_R3: assert ({~carryOutN, result} == addSum)
        else $error("add with carry mismatch");
    if (logicMode && funcSel == 4'd6)
      assert_xor_R1: assert (result == (opA ^ opB))
        else $error("xor mismatch");
    if (logicMode && funcSel == 4'd3)
      assert_const_zero_R8: assert (result == '0)
        else $error("logic constant zero mismatch");
  end
endmodule

bind quad_alu quad_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .opA(opA), .opB(opB), .funcSel(funcSel), .logicMode(logicMode),
  .carryInN(carryInN), .result(result), .carryOutN(carryOutN),
  .grpGenN(grpGenN), .grpPropN(grpPropN), .allOnes(allOnes)
);

// File: tb/quad_alu_test.sv
module quad_alu_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] opA, opB, funcSel, result;
  logic logicMode, carryInN, carryOutN, grpGenN, grpPropN, allOnes;
  int testsRun = 0;
  int testsFailed = 0;

  quad_alu uut (
    .opA(opA), .opB(opB), .funcSel(funcSel), .logicMode(logicMode),
    .carryInN(carryInN), .result(result), .carryOutN(carryOutN),
    .grpGenN(grpGenN), .grpPropN(grpPropN), .allOnes(allOnes)
  );

  function automatic logic [3:0] refLogic(input logic [3:0] s, a, b);
    case (s)
      4'd0: return ~a;        4'd1: return ~a & ~b;
      4'd2: return ~a & b;    4'd3: return 4'h0;
      4'd4: return ~(a & b);  4'd5: return ~b;
      4'd6: return a ^ b;     4'd7: return a & ~b;
      4'd8: return ~a | b;    4'd9: return ~(a ^ b);
      4'd10: return b;        4'd11: return a & b;
      4'd12: return 4'hF;     4'd13: return a | ~b;
      4'd14: return a | b;    default: return a;
    endcase
  endfunction

  // full five-bit sum with no carry in, minus one counted as adding 1111
  function automatic logic [4:0] refSum(input logic [3:0] s, a, b);
    logic [4:0] ea, eb, anb, aab, aob, aonb;
    ea = {1'b0, a}; eb = {1'b0, b};
    anb = {1'b0, a & ~b}; aab = {1'b0, a & b};
    aob = {1'b0, a | b}; aonb = {1'b0, a | ~b};
    case (s)
      4'd0: return ea;             4'd1: return aob;
      4'd2: return aonb;           4'd3: return 5'd15;
      4'd4: return ea + anb;       4'd5: return aob + anb;
      4'd6: return ea + {1'b0, ~b}; 4'd7: return anb + 5'd15;
      4'd8: return ea + aab;       4'd9: return ea + eb;
      4'd10: return aonb + aab;    4'd11: return aab + 5'd15;
      4'd12: return ea + ea;       4'd13: return aob + ea;
      4'd14: return aonb + ea;     default: return ea + 5'd15;
    endcase
  endfunction

  task automatic check(input string tag, input logic [4:0] got, exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h (S=%h M=%b Cn=%b A=%h B=%h)",
               tag, got, exp, funcSel, logicMode, carryInN, opA, opB);
    end
  endtask

  task automatic runVec(input logic [3:0] s, input logic m, cn, input logic [3:0] a, b);
    logic [4:0] full, noCarry;
    logic [3:0] expF;
    string tag;
    @(posedge clk);
    #1;
    funcSel = s; logicMode = m; carryInN = cn; opA = a; opB = b;
    noCarry = refSum(s, a, b);
    full = noCarry + {4'd0, ~cn};
    if (m) begin
      expF = refLogic(s, a, b);
      tag = cn ? "R1" : "R4";
    end else begin
      expF = full[3:0];
      tag = cn ? "R2" : "R3";
    end
    @(negedge clk);  // combinational: due in the same cycle
    check(tag, {1'b0, result}, {1'b0, expF});
    check("R5", {4'd0, carryOutN}, {4'd0, ~full[4]});
    check("R6", {4'd0, grpGenN}, {4'd0, ~noCarry[4]});
    check("R7", {4'd0, allOnes}, {4'd0, (expF == 4'hF)});
  endtask

  initial begin
    #(4 * 150000);
    testsFailed++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    funcSel = 4'd0; logicMode = 1'b1; carryInN = 1'b1; opA = 4'd0; opB = 4'd0;
    @(negedge clk);
    // reset-free start: all-zero logic code 0 gives NOT A = 1111 (R1)
    check("R1", {1'b0, result}, 5'h0F);
    check("R7", {4'd0, allOnes}, 5'd1);

    for (int m = 0; m < 2; m++)
      for (int cn = 0; cn < 2; cn++)
        for (int s = 0; s < 16; s++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
              runVec(4'(s), 1'(m), 1'(cn), 4'(a), 4'(b));

    // R8 directed constants
    for (int k = 0; k < 8; k++) begin
      runVec(4'd3, 1'b1, 1'(k), 4'(k * 3), 4'(k * 5));
      check("R8", {1'b0, result}, 5'h00);
      runVec(4'd12, 1'b1, 1'(k), 4'(k * 7), 4'(k + 2));
      check("R8", {1'b0, result}, 5'h0F);
      runVec(4'd3, 1'b0, 1'b1, 4'(k * 9), 4'(k * 11));
      check("R8", {1'b0, result}, 5'h0F);
    end
    // R7 equality detection through subtraction
    runVec(4'd6, 1'b0, 1'b1, 4'd9, 4'd9);
    check("R7", {4'd0, allOnes}, 5'd1);
    runVec(4'd6, 1'b0, 1'b1, 4'd9, 4'd8);
    check("R7", {4'd0, allOnes}, 5'd0);
    // R3 wrap: 15+15+1 = 31
    runVec(4'd9, 1'b0, 1'b0, 4'd15, 4'd15);
    check("R3", {~carryOutN, result}, 5'd31);

    void'($urandom(32'h1234ABCD));
    for (int n = 0; n < 3000; n++)
      runVec(4'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom));

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule